// File: doc/BRIEF.md
# Split-Aligned Multichannel Counter PWM

This block produces a bank of pulse-width-modulated outputs from one shared free-running count. Every channel holds its own duty value and compares it against the shared count. The lower half of the channels compare against the count as it stands, so their pulses start at the beginning of each period. The upper half compare against the bitwise complement of the count, which runs downward, so their pulses finish at the end of each period. When both halves carry similar duties, their rising and falling edges fall at different points of the period. This spreads the switching current of the loads instead of having every output rise on the same clock.

Software or a control loop writes a duty value through a single write port that carries a channel index and an enable. The value goes into a shadow register. It reaches the comparator only when the count wraps, so a pulse is never cut short or stretched partway through a period. The period is 2^RES clocks, and the refresh rate is the clock rate divided by 2^RES.

Top module: `split_pwm`

## Requirements
- R1: A single RES-bit count starts at 0 after reset, rises by one on every clock, and wraps from 2^RES-1 back to 0. The output period is therefore 2^RES clocks.
- R2: A channel output is high exactly while its compared count is strictly less than the channel's active duty value, so a duty of d gives d high clocks per period.
- R3: Channels 0 to NUM_CH/2-1 compare against the count itself: their high time covers counts 0 to d-1 at the start of the period.
- R4: Channels NUM_CH/2 to NUM_CH-1 compare against the bitwise complement of the count: their high time covers counts 2^RES-d to 2^RES-1 at the end of the period.
- R5: A duty written while wr_en is high goes to the shadow register of channel wr_ch only. The active value takes the shadow value on the clock edge at which the count wraps from 2^RES-1 to 0, and holds steady at every other edge.
- R6: An active duty of 0 keeps the output low for the whole period.
- R7: An active duty of 2^RES-1 keeps the output high for all counts but one. That count is 2^RES-1 for the lower half and 0 for the upper half.
- R8: While rst_n is low at a clock edge, the count, all shadow values and all active values clear to 0, and every output is low. All outputs stay low after reset until new duties are written and a wrap occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe for the duty port |
| wr_ch | input | $clog2(NUM_CH) | Channel selected by the write |
| wr_duty | input | RES | Duty value written to the shadow register |
| pwm_out | output | NUM_CH | PWM outputs, bit i belongs to channel i |

## Verification
The in-line assertions check the count on every cycle: it steps by one and wraps to zero. They also check that an active duty moves only on the wrap edge and then equals the shadow value, that a zero duty never drives an output high, and that a full-scale duty drops low only on the one count its alignment predicts. The start-of-period and end-of-period placement of the two groups, the exact number of high clocks per period, the length of the period, and the clearing effect of a reset in the middle of a period can only be seen over whole periods. The bench shows these by running a reference model alongside the block and by counting and timing pulses in directed scenarios.

// File: rtl/spwm_pkg.sv
// Package: spwm_pkg
// Shared definitions for the split-aligned PWM. Holds the alignment
// choice that selects how a channel views the shared count.
package spwm_pkg;

    // Where a channel's pulse sits inside the period.
    typedef enum logic {
        ALIGN_START = 1'b0,   // compare against the count as it runs upward
        ALIGN_END   = 1'b1    // compare against the complemented count
    } align_e;

endpackage

// File: rtl/spwm_counter.sv
// Module: spwm_counter
// The free-running period count that all channels share. It steps once
// per clock and wraps naturally at 2^RES. It also flags the final count
// of the period, which the channels use to load their new duty values.
// Assumes: a synchronous active-low reset, and RES >= 2.
module spwm_counter #(
    parameter int RES = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    output logic [RES-1:0] cnt,
    output logic           last
);

    localparam logic [RES-1:0] TOP = {RES{1'b1}};

    // Advance the period count, or clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt + 1'b1;
    end

    // Mark the last count of the period.
    always_comb last = (cnt == TOP);

    // R1: the count steps by one everywhere except at the top.
    assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !last |=> (cnt == RES'($past(cnt) + 1'b1)));

    // R1: the count returns to zero after the top.
    assert_count_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> (cnt == '0));

endmodule

// File: rtl/spwm_channel.sv
// Module: spwm_channel
// One PWM channel. It holds a shadow duty register that the write port
// fills, an active duty register that loads from the shadow on the
// wrap edge, and a comparator. ALIGN chooses whether the comparator
// sees the count itself or its complement.
// Assumes: cnt and last come from spwm_counter in the same clock domain.
module spwm_channel
    import spwm_pkg::*;
#(
    parameter int     RES   = 8,
    parameter align_e ALIGN = ALIGN_START
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_hit,
    input  logic [RES-1:0] wr_duty,
    input  logic [RES-1:0] cnt,
    input  logic           last,
    output logic           pwm
);

    localparam logic [RES-1:0] FULL = {RES{1'b1}};

    logic [RES-1:0] shadow_q;
    logic [RES-1:0] active_q;
    logic [RES-1:0] view;

    // Capture a written duty in the shadow register.
    always_ff @(posedge clk) begin
        if (!rst_n)      shadow_q <= '0;
        else if (wr_hit) shadow_q <= wr_duty;
    end

    // Move the shadow duty into use only at the end of a period.
    always_ff @(posedge clk) begin
        if (!rst_n)    active_q <= '0;
        else if (last) active_q <= shadow_q;
    end

    // Pick the channel's view of the count according to its alignment.
    generate
        if (ALIGN == ALIGN_END) begin : g_end
            always_comb view = ~cnt;
        end else begin : g_start
            always_comb view = cnt;
        end
    endgenerate

    // Drive the output high while the viewed count is under the duty.
    always_comb pwm = (view < active_q);

    // R5: the active duty is stable away from the wrap edge.
    assert_hold_active_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !last |=> $stable(active_q));

    // R5: at the wrap edge the active duty takes the shadow value.
    assert_load_active_R5: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> (active_q == $past(shadow_q)));

    // R6: a zero duty never lets the output go high.
    assert_zero_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q == '0) |-> !pwm);

    // R7: a full-scale duty is low only on the single count set by its alignment.
    generate
        if (ALIGN == ALIGN_END) begin : g_full_end
            assert_full_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (active_q == FULL && !pwm) |-> (cnt == '0));
        end else begin : g_full_start
            assert_full_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (active_q == FULL && !pwm) |-> last);
        end
    endgenerate

endmodule

// File: rtl/split_pwm.sv
// Module: split_pwm
// Top of the split-aligned multichannel PWM. One shared count drives
// NUM_CH channels. The lower half of the channels are start-aligned and
// the upper half end-aligned. A single write port decodes the channel
// index to one shadow register.
// Assumes: NUM_CH is even and at least 2, RES >= 2, and reset is synchronous.
module split_pwm
    import spwm_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int RES    = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [$clog2(NUM_CH)-1:0] wr_ch,
    input  logic [RES-1:0]            wr_duty,
    output logic [NUM_CH-1:0]         pwm_out
);

    localparam int CH_W = $clog2(NUM_CH);
    localparam int HALF = NUM_CH / 2;

    logic [RES-1:0] cnt;
    logic           last;

    spwm_counter #(.RES(RES)) u_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .cnt   (cnt),
        .last  (last)
    );

    // Create one channel per output. The first half is start-aligned.
    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
            localparam align_e CH_ALIGN = (i < HALF) ? ALIGN_START : ALIGN_END;
            logic hit;

            // Decode the write port for this channel.
            always_comb hit = wr_en && (wr_ch == CH_W'(i));

            spwm_channel #(.RES(RES), .ALIGN(CH_ALIGN)) u_ch (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_hit  (hit),
                .wr_duty (wr_duty),
                .cnt     (cnt),
                .last    (last),
                .pwm     (pwm_out[i])
            );
        end
    endgenerate

endmodule

// File: tb/split_pwm_bench.sv
module split_pwm_bench;

    localparam int NUM_CH = 8;
    localparam int RES    = 8;
    localparam int CH_W   = $clog2(NUM_CH);
    localparam int HALF   = NUM_CH / 2;
    localparam int PER    = 1 << RES;
    localparam logic [RES-1:0] TOP = {RES{1'b1}};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [CH_W-1:0]   wr_ch = '0;
    logic [RES-1:0]    wr_duty = '0;
    logic [NUM_CH-1:0] pwm_out;

    int vectors = 0;
    int errors  = 0;
    int cycles  = 0;
    bit started = 1'b0;

    // reference model state
    logic [RES-1:0] m_cnt = '0;
    logic [RES-1:0] m_sh  [NUM_CH];
    logic [RES-1:0] m_act [NUM_CH];

    split_pwm #(.NUM_CH(NUM_CH), .RES(RES)) u_split_pwm (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_ch   (wr_ch),
        .wr_duty (wr_duty),
        .pwm_out (pwm_out)
    );

    always #2 clk = ~clk;   // 250 MHz

    function automatic logic exp_bit(input int ch, input logic [RES-1:0] c, input logic [RES-1:0] d);
        logic [RES-1:0] v;
        v = (ch < HALF) ? c : ~c;
        return v < d;
    endfunction

    // model update, mirroring the requirements R1, R5, R8
    always @(posedge clk) begin
        started = 1'b1;
        cycles++;
        if (!rst_n) begin
            m_cnt = '0;
            for (int i = 0; i < NUM_CH; i++) begin m_sh[i] = '0; m_act[i] = '0; end
        end else begin
            if (m_cnt == TOP)
                for (int i = 0; i < NUM_CH; i++) m_act[i] = m_sh[i];
            if (wr_en) m_sh[wr_ch] = wr_duty;
            m_cnt = m_cnt + 1'b1;
        end
    end

    // per-cycle comparison of every output against the model
    always @(negedge clk) begin
        if (started) begin
            for (int i = 0; i < NUM_CH; i++) begin
                logic e;
                string tag;
                e = exp_bit(i, m_cnt, m_act[i]);
                if (!rst_n)                 tag = "R8";
                else if (m_act[i] == '0)    tag = "R6";
                else if (m_act[i] == TOP)   tag = "R7";
                else if (i < HALF)          tag = "R3";
                else                        tag = "R4";
                vectors++;
                if (pwm_out[i] !== e) begin
                    errors++;
                    $display("FAIL %s ch%0d cnt=%0d: actual=%b expected=%b", tag, i, m_cnt, pwm_out[i], e);
                end
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        if (cycles > 150000) begin
            errors++;
            $display("FAIL R1 watchdog expired: actual=%0d cycles expected<=150000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic write(input int ch, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_ch = CH_W'(ch); wr_duty = RES'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // align to the negedge that shows count 0 of a fresh period
    task automatic to_period_start();
        do @(negedge clk); while (m_cnt != 1);
        do @(negedge clk); while (m_cnt != 0);
    endtask

    // observe one full period of one channel, starting at count 0
    task automatic observe(input int ch, output int hi, output int first_on, output int last_on);
        hi = 0; first_on = -1; last_on = -1;
        to_period_start();
        for (int k = 0; k < PER; k++) begin
            if (pwm_out[ch]) begin
                hi++;
                if (first_on < 0) first_on = k;
                last_on = k;
            end
            if (k != PER - 1) @(negedge clk);
        end
    endtask

    initial begin
        int hi, f, l;
        int rise_a, rise_b;
        logic prev;
        repeat (3) @(negedge clk);
        check("R8 outputs during reset", int'(pwm_out), 0);
        rst_n = 1'b1;

        // R8: nothing written yet -> outputs stay low for a full period
        observe(0, hi, f, l);
        check("R8 low after reset ch0", hi, 0);
        observe(NUM_CH - 1, hi, f, l);
        check("R8 low after reset last ch", hi, 0);

        // R2 and R3: start-aligned duty 100
        write(1, 100);
        observe(1, hi, f, l);
        check("R2 high clocks ch1", hi, 100);
        check("R3 first high count ch1", f, 0);
        check("R3 last high count ch1", l, 99);

        // R2 and R4: end-aligned duty 100
        write(5, 100);
        observe(5, hi, f, l);
        check("R2 high clocks ch5", hi, 100);
        check("R4 first high count ch5", f, PER - 100);
        check("R4 last high count ch5", l, PER - 1);

        // R7: full scale on both groups
        write(2, PER - 1);
        write(6, PER - 1);
        observe(2, hi, f, l);
        check("R7 high clocks ch2", hi, PER - 1);
        check("R7 low only at top ch2", l, PER - 2);
        observe(6, hi, f, l);
        check("R7 high clocks ch6", hi, PER - 1);
        check("R7 low only at zero ch6", f, 1);

        // R6: zero duty
        write(1, 0);
        observe(1, hi, f, l);
        check("R6 zero duty ch1", hi, 0);

        // R1: period length from two rising edges of a duty-1 channel
        write(0, 1);
        to_period_start();
        rise_a = -1; rise_b = -1; prev = pwm_out[0];
        for (int k = 1; k <= 2 * PER + 2; k++) begin
            @(negedge clk);
            if (pwm_out[0] && !prev) begin
                if (rise_a < 0) rise_a = k; else if (rise_b < 0) rise_b = k;
            end
            prev = pwm_out[0];
        end
        check("R1 period in clocks", rise_b - rise_a, PER);

        // R5: mid-period write does not change the current period
        to_period_start();
        repeat (40) @(negedge clk);
        write(3, 200);
        hi = 0;
        while (m_cnt != 0) begin
            if (pwm_out[3]) hi++;
            @(negedge clk);
        end
        check("R5 old duty kept to period end ch3", hi, 0);
        observe(3, hi, f, l);
        check("R5 new duty after wrap ch3", hi, 200);
        check("R5 other channel untouched ch4", int'(m_act[4]), 0);
        observe(4, hi, f, l);
        check("R5 ch4 output still low", hi, 0);

        // write landing on the wrap edge goes to the next period (R5)
        do @(negedge clk); while (m_cnt != TOP - 1);
        @(negedge clk);
        wr_en = 1'b1; wr_ch = CH_W'(7); wr_duty = RES'(50);
        @(negedge clk);
        wr_en = 1'b0;
        hi = 0;
        for (int k = 0; k < PER - 1; k++) begin
            if (pwm_out[7]) hi++;
            @(negedge clk);
        end
        check("R5 wrap-edge write deferred ch7", hi, 0);

        // random stimulus with fixed seed, checked by the model each cycle
        void'($urandom(32'h5eed_1234));
        for (int k = 0; k < 12 * PER; k++) begin
            @(negedge clk);
            if (($urandom % 12) == 0) begin
                int r;
                wr_en = 1'b1;
                wr_ch = CH_W'($urandom % NUM_CH);
                r = $urandom % 8;
                wr_duty = (r == 0) ? '0 : (r == 1) ? TOP : RES'($urandom);
            end else begin
                wr_en = 1'b0;
            end
        end
        @(negedge clk);
        wr_en = 1'b0;

        // R8: reset in the middle of a period clears everything
        repeat (77) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R8 outputs cleared mid-run", int'(pwm_out), 0);
        rst_n = 1'b1;
        observe(6, hi, f, l);
        check("R8 end group low after reset", hi, 0);
        observe(2, hi, f, l);
        check("R8 start group low after reset", hi, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule